// File: doc/BRIEF.md
# Dual-Converter Channel Lane Serializer

This block collects 8-bit conversion results from a group of readout channels and sends them out on one serial lane. Each channel owns two converters, A and B, that take turns: a conversion lasts two line slots, so with the pair staggered, every channel produces one fresh result per slot. In each slot the block listens only to the converter whose turn it is. It keeps that converter's finished result and, at the slot boundary, packs the results of all channels into one word. That word is shifted out MSB first in the following slot, one bit per clock.

The whole block runs in a single bit-clock domain. A slot lasts exactly as many clocks as the word has bits, which is six channels times eight bits, or 48. The words therefore leave back to back with no idle bits. At a 600 Mb/s lane rate one slot lasts 80 ns. A one-cycle line sync pulse starts the slot timing once after reset.

A channel whose expected done strobe never arrives is sent as 0xFF, and a sticky error flag is raised. The sequencer has three states. `ST_IDLE` waits for the sync. `ST_FILL` collects the first slot while the lane is still silent. `ST_STREAM` shifts out one word while it collects the next. The transitions are: `ST_IDLE` to `ST_FILL` on the sync pulse, `ST_FILL` to `ST_STREAM` on the last cycle of the first slot, and `ST_STREAM` to itself until reset.

Top module: `adc_lane_serializer`

## Requirements
- R1: While reset is asserted, and after it until the first word is loaded, `bit_en`, `frame_mark`, `ser_bit` and `err_flag` are all 0.
- R2: A `line_sync` pulse in idle starts slot 0 in the cycle that follows it. `bit_en` stays 0 for the 48 cycles of slot 0 and rises in the first cycle after them.
- R3: Slots alternate converters, starting with A (the `adc_a_*` buses) in slot 0, then B, then A, and so on. A done strobe from the converter whose turn it is not is ignored, so that channel counts as missing.
- R4: The 48-bit word is channel 0 first, then ascending channels, each byte MSB first. Channel i's data sits at bits [8i+7:8i] of the data buses.
- R5: `frame_mark` is 1 on the first bit of every word and 0 on all other bits.
- R6: Once streaming, `bit_en` stays 1 and a new word starts every 48 cycles with no gap.
- R7: A channel with no accepted strobe in a slot is sent as 0xFF.
- R8: `err_flag` rises when a word containing a missing channel is loaded, and stays 1 until reset.
- R9: A `line_sync` pulse after the first one has no effect on the word timing or content.
- R10: A strobe in the last cycle of a slot goes into that slot's word.
- R11: Done strobes seen while idle are discarded and do not reach the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_sync | input | 1 | One-cycle pulse that starts slot timing |
| adc_a_data | input | 48 | Converter A results, channel i at [8i+7:8i] |
| adc_a_done | input | 6 | Converter A done strobes, one per channel |
| adc_b_data | input | 48 | Converter B results, channel i at [8i+7:8i] |
| adc_b_done | input | 6 | Converter B done strobes, one per channel |
| ser_bit | output | 1 | Serial data bit |
| frame_mark | output | 1 | High on the first bit of each word |
| bit_en | output | 1 | High when `ser_bit` carries word data |
| err_flag | output | 1 | Sticky missing-result flag |

## Verification
The hardest case to reach from the ports is a strobe that lands exactly on the slot boundary. It happens while the previous word is still streaming and the converter turn is about to flip. A strobe on the wrong converter in the same slot is similarly awkward. The bench tracks its own slot and cycle count from the sync pulse. It places each strobe at a chosen cycle, including the last cycle of a slot, and it drives the opposite converter to mimic a misrouted result. A separate monitor reassembles every word from the serial bits and checks it against the value expected from the table row.

// File: rtl/lane_ser_pkg.sv
package lane_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_STREAM = 2'd2
    } slot_state_e;

    localparam logic [7:0] MISS_FILL = 8'hFF;

endpackage

// File: rtl/lane_slot_seq.sv
module lane_slot_seq
    import lane_ser_pkg::*;
#(
    parameter int SLOT_LEN = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_sync,
    output logic cap_en,
    output logic load,
    output logic phase
);

    localparam int CW = (SLOT_LEN > 2) ? $clog2(SLOT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_LEN - 1);

    slot_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (line_sync) state_d = ST_FILL;
            ST_FILL:   if (at_last)   state_d = ST_STREAM;
            ST_STREAM: state_d = ST_STREAM;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cnt_q   <= '0;
                phase_q <= 1'b0;
            end else if (at_last) begin
                cnt_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        cap_en = 1'b0;
        load   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cap_en = 1'b0;
                load   = 1'b0;
            end
            ST_FILL, ST_STREAM: begin
                cap_en = 1'b1;
                load   = at_last;
            end
            default: begin
                cap_en = 1'b0;
                load   = 1'b0;
            end
        endcase
    end

    assign phase = phase_q;

    AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !load);                              // R2
    AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase_q != $past(phase_q)));                        // R3
    AST_STREAM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM) |=> (state_q == ST_STREAM));           // R6

endmodule

// File: rtl/lane_chan_pick.sv
module lane_chan_pick
    import lane_ser_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             load,
    input  logic             phase,
    input  logic [RES_W-1:0] a_data,
    input  logic             a_done,
    input  logic [RES_W-1:0] b_data,
    input  logic             b_done,
    output logic [RES_W-1:0] result,
    output logic             missing
);

    logic [RES_W-1:0] hold_q;
    logic             valid_q;
    logic             hit;
    logic [RES_W-1:0] sel_data;

    assign hit      = cap_en && (phase ? b_done : a_done);
    assign sel_data = phase ? b_data : a_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b0;
        end else if (hit) begin
            hold_q  <= sel_data;
            valid_q <= 1'b1;
        end
    end

    always_comb begin
        if (hit)          result = sel_data;
        else if (valid_q) result = hold_q;
        else              result = {RES_W{1'b1}};
        missing = !hit && !valid_q;
    end

    AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !valid_q);                                           // R7
    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> (valid_q == $past(valid_q)) || !valid_q);         // R11

endmodule

// File: rtl/lane_frame_shift.sv
module lane_frame_shift #(
    parameter int WORD_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              miss_any,
    output logic              ser_bit,
    output logic              frame_mark,
    output logic              bit_en,
    output logic              err_flag
);

    logic [WORD_W-1:0] sh_q;
    logic              mark_q;
    logic              en_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            mark_q <= 1'b0;
            en_q   <= 1'b0;
            err_q  <= 1'b0;
        end else if (load) begin
            sh_q   <= word;
            mark_q <= 1'b1;
            en_q   <= 1'b1;
            err_q  <= err_q | miss_any;
        end else begin
            sh_q   <= sh_q << 1;
            mark_q <= 1'b0;
        end
    end

    assign ser_bit    = sh_q[WORD_W-1];
    assign frame_mark = mark_q;
    assign bit_en     = en_q;
    assign err_flag   = err_q;

    AST_MARK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mark_q |-> en_q);                                             // R5
    AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_q |=> !mark_q);                                          // R5
    AST_EN_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);                                               // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);                                             // R8

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
    import lane_ser_pkg::*;
#(
    parameter int CH_NUM = 6,
    parameter int RES_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_sync,
    input  logic [CH_NUM*RES_W-1:0] adc_a_data,
    input  logic [CH_NUM-1:0]       adc_a_done,
    input  logic [CH_NUM*RES_W-1:0] adc_b_data,
    input  logic [CH_NUM-1:0]       adc_b_done,
    output logic                    ser_bit,
    output logic                    frame_mark,
    output logic                    bit_en,
    output logic                    err_flag
);

    localparam int WORD_W = CH_NUM * RES_W;

    logic              cap_en;
    logic              load;
    logic              phase;
    logic [WORD_W-1:0] word;
    logic [CH_NUM-1:0] miss_vec;

    lane_slot_seq #(.SLOT_LEN(WORD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .cap_en    (cap_en),
        .load      (load),
        .phase     (phase)
    );

    for (genvar gi = 0; gi < CH_NUM; gi++) begin : g_ch
        lane_chan_pick #(.RES_W(RES_W)) u_pick (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_en  (cap_en),
            .load    (load),
            .phase   (phase),
            .a_data  (adc_a_data[gi*RES_W +: RES_W]),
            .a_done  (adc_a_done[gi]),
            .b_data  (adc_b_data[gi*RES_W +: RES_W]),
            .b_done  (adc_b_done[gi]),
            .result  (word[WORD_W-1-gi*RES_W -: RES_W]),
            .missing (miss_vec[gi])
        );
    end

    lane_frame_shift #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .word       (word),
        .miss_any   (|miss_vec),
        .ser_bit    (ser_bit),
        .frame_mark (frame_mark),
        .bit_en     (bit_en),
        .err_flag   (err_flag)
    );

    AST_QUIET_BEFORE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |-> (!ser_bit && !frame_mark && !err_flag));          // R1

endmodule

// File: tb/adc_lane_serializer_tb_top.sv
module adc_lane_serializer_tb_top;

    localparam int CH = 6;
    localparam int RW = 8;
    localparam int WW = CH * RW;
    localparam int NV = 8;

    // row = {sync_mid, late_ch5, wrong[5:0], present[5:0], data[47:0]}, data byte for ch i at [47-8i -: 8]
    localparam logic [61:0] TBL [NV] = '{
        {1'b0, 1'b0, 6'h00, 6'h3F, 48'h0123456789AB},
        {1'b0, 1'b0, 6'h00, 6'h3F, 48'hA55A0FF08001},
        {1'b0, 1'b1, 6'h00, 6'h3F, 48'hFE7F80017E81},
        {1'b1, 1'b0, 6'h00, 6'h3F, 48'h102030405060},
        {1'b0, 1'b0, 6'h00, 6'h3B, 48'hC3C3C3C3C3C3},
        {1'b0, 1'b0, 6'h21, 6'h3F, 48'h111111111111},
        {1'b0, 1'b0, 6'h00, 6'h3F, 48'h00FF00FF0000},
        {1'b0, 1'b0, 6'h00, 6'h00, 48'h89ABCDEF0246}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_sync = 1'b0;
    logic [WW-1:0] adc_a_data = '0;
    logic [CH-1:0] adc_a_done = '0;
    logic [WW-1:0] adc_b_data = '0;
    logic [CH-1:0] adc_b_done = '0;
    logic ser_bit, frame_mark, bit_en, err_flag;

    int checks = 0;
    int fails  = 0;

    logic [WW-1:0] exp_word [NV];
    logic          exp_err  [NV];
    logic          mon_on = 1'b0;
    int            mon_k = 0;
    int            mon_idx = 0;
    logic          mon_started = 1'b0;
    logic [WW-1:0] mon_word = '0;

    always #2.5 clk = ~clk;

    adc_lane_serializer #(.CH_NUM(CH), .RES_W(RW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_sync  (line_sync),
        .adc_a_data (adc_a_data),
        .adc_a_done (adc_a_done),
        .adc_b_data (adc_b_data),
        .adc_b_done (adc_b_done),
        .ser_bit    (ser_bit),
        .frame_mark (frame_mark),
        .bit_en     (bit_en),
        .err_flag   (err_flag)
    );

    task automatic check(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_slot(input int s, input logic [61:0] row);
        automatic logic [WW-1:0] d = row[47:0];
        automatic logic [5:0] pres = row[53:48];
        automatic logic [5:0] wrong = row[59:54];
        automatic bit late = row[60];
        automatic bit syn = row[61];
        for (int c = 0; c < WW; c++) begin
            adc_a_done = '0;
            adc_b_done = '0;
            adc_a_data = {CH{8'h5A}};
            adc_b_data = {CH{8'hA5}};
            line_sync  = syn && (c == 20);
            for (int i = 0; i < CH; i++) begin
                automatic int at = (i == 5 && late) ? WW - 1 : 2 + 4 * i;
                if (pres[i] && c == at) begin
                    if (((s % 2) == 0) ^ wrong[i]) begin
                        adc_a_done[i] = 1'b1;
                        adc_a_data[i*RW +: RW] = d[WW-1-i*RW -: RW];
                    end else begin
                        adc_b_done[i] = 1'b1;
                        adc_b_data[i*RW +: RW] = d[WW-1-i*RW -: RW];
                    end
                end
            end
            @(negedge clk);
        end
        adc_a_done = '0;
        adc_b_done = '0;
        line_sync  = 1'b0;
    endtask

    // monitor: reassemble words from the lane (R4, R5, R6)
    always @(negedge clk) begin
        if (mon_on) begin
            if (mon_started && !bit_en) begin
                checks++; fails++;
                $display("FAIL R6 gap in bit_en actual=0 expected=1");
            end
            if (bit_en) begin
                if (frame_mark) begin
                    if (mon_started && mon_idx != WW) begin
                        checks++; fails++;
                        $display("FAIL R5 early frame_mark actual=%0d expected=%0d", mon_idx, WW);
                    end
                    mon_idx = 0;
                    mon_word = '0;
                    mon_started = 1'b1;
                end else if (mon_idx == WW) begin
                    checks++; fails++;
                    $display("FAIL R5 missing frame_mark actual=0 expected=1");
                    mon_idx = 0;
                end
                if (mon_started) begin
                    mon_word = {mon_word[WW-2:0], ser_bit};
                    mon_idx++;
                    if (mon_idx == WW && mon_k < NV) begin
                        // R3 R4 R7 R9 R10: content per table row
                        check(mon_word == exp_word[mon_k], "R4 R3 R7 R9 R10 word", mon_word, exp_word[mon_k]);
                        check(err_flag == exp_err[mon_k], "R8 err_flag", {47'b0, err_flag}, {47'b0, exp_err[mon_k]});
                        mon_k++;
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        automatic logic run_err = 1'b0;
        automatic logic [WW-1:0] got;
        // R1: reset state
        repeat (3) @(negedge clk);
        check({bit_en, frame_mark, ser_bit, err_flag} == 4'b0, "R1 reset outputs",
              {44'b0, bit_en, frame_mark, ser_bit, err_flag}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // expected words from the requirements
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < CH; i++) begin
                if (TBL[v][48+i] && !TBL[v][54+i])
                    exp_word[v][WW-1-i*RW -: RW] = TBL[v][WW-1-i*RW -: RW];
                else begin
                    exp_word[v][WW-1-i*RW -: RW] = 8'hFF;
                    run_err = 1'b1;
                end
            end
            exp_err[v] = run_err;
        end
        mon_on = 1'b1;
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
        for (int s = 0; s < NV; s++) drive_slot(s, TBL[s]);
        while (mon_k < NV) @(negedge clk);
        mon_on = 1'b0;

        // directed: reset mid-stream (R1)
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({bit_en, frame_mark, ser_bit, err_flag} == 4'b0, "R1 outputs after mid-run reset",
              {44'b0, bit_en, frame_mark, ser_bit, err_flag}, '0);
        rst_n = 1'b1;
        // R11: strobes while idle are discarded
        adc_a_done = '1;
        adc_a_data = {CH{8'h11}};
        adc_b_done = '1;
        adc_b_data = {CH{8'h22}};
        repeat (3) @(negedge clk);
        adc_a_done = '0;
        adc_b_done = '0;
        check(bit_en == 1'b0, "R1 bit_en idle", {47'b0, bit_en}, '0);
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
        // R2: silent during the first slot
        for (int c = 0; c < WW; c++) begin
            if (c == 0 || c == WW - 1)
                check(bit_en == 1'b0, "R2 bit_en low in fill slot", {47'b0, bit_en}, '0);
            @(negedge clk);
        end
        check(bit_en == 1'b1, "R2 bit_en rises after fill slot", {47'b0, bit_en}, 48'd1);
        check(frame_mark == 1'b1, "R5 frame_mark on first bit", {47'b0, frame_mark}, 48'd1);
        got = '0;
        for (int b = 0; b < WW; b++) begin
            got = {got[WW-2:0], ser_bit};
            @(negedge clk);
        end
        check(got == {WW{1'b1}}, "R11 R7 idle strobes dropped, all 0xFF", got, {WW{1'b1}});
        check(err_flag == 1'b1, "R8 err_flag after missing word", {47'b0, err_flag}, 48'd1);
        check(bit_en && frame_mark, "R6 next word starts without gap",
              {46'b0, bit_en, frame_mark}, 48'd3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule